// File: doc/BRIEF.md
# Doorbell-Started Transmit Descriptor Engine

This block moves one outgoing frame from memory to a MAC-side byte stream under software control. Software places a four-word descriptor in memory and loads the descriptor's byte address into a base register. A write of the start key to the poll register then makes the engine fetch the descriptor's control word. If the control word hands the frame to hardware and is well formed, the engine fetches the buffer address and reads the frame a 32-bit word at a time. It sends the frame out one byte per beat on a valid/ready stream.

When the last byte has been accepted, the engine writes the control word back with the ownership flag cleared. Software can poll that flag, or watch the done bit in the status output. A descriptor that is still owned by software produces no activity. A malformed descriptor is left untouched and flags an error.

Memory is reached through a word-addressed request port. A request is held until the memory acknowledges it, and read data is taken in the acknowledge cycle.

Top module: `tx_desc_dma`

## Requirements
- R1: A register write with `reg_sel` = 1 and data exactly 0x00000040, while idle, starts a fetch of descriptor word 0. A write of any other value to that register starts nothing.
- R2: Register 0 holds the descriptor byte address, with its low 4 bits ignored. Word 0 sits at that address and word 2, the buffer byte address, sits 8 bytes above it. In word 0, bit 31 is ownership, bit 29 is first-segment, bit 28 is last-segment, and bits 15:0 are the length in bytes.
- R3: If word 0 has bit 31 clear, no byte is streamed, memory is not written, the status is unchanged and the engine returns to idle.
- R4: If word 0 has bit 31 set but bit 29 or bit 28 is clear, or the length is 0, then no byte is streamed, word 0 stays unchanged in memory and status bit 3 (error) is set.
- R5: The frame bytes leave in ascending address order, starting at any byte offset of the buffer address. Within a 32-bit memory word, byte lane 0 (bits 7:0) is the lowest address.
- R6: `m_tlast` is high on the final byte of the frame only, including for a one-byte frame.
- R7: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata` and `m_tlast` hold their values.
- R8: After the last byte is accepted, word 0 is written back with bit 31 cleared and all other bits as fetched. Every memory request holds its address and direction until `mem_ack`.
- R9: Status bit 2 (done) is set when the write-back is acknowledged. Writing `reg_sel` = 2 with a 1 in bit 2 or bit 3 clears that status bit. A set in the same cycle wins over a clear.
- R10: Poll and base writes made while a descriptor is in progress do not start or redirect a transfer.
- R11: After reset, `m_tvalid`, `mem_req` and `int_status` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 base, 1 poll, 2 status clear |
| reg_wdata | input | 32 | Register write data |
| int_status | output | 8 | Bit 2 done, bit 3 error, others 0 |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge, ends the request |
| m_tvalid | output | 1 | Stream byte valid |
| m_tready | input | 1 | Stream sink ready |
| m_tdata | output | 8 | Stream byte |
| m_tlast | output | 1 | Final byte of frame |

## Verification
The bench builds the engine with a 12-bit byte address, so a 1024-word memory model covers every descriptor and buffer the tests place. This makes it cheap to put buffers at unaligned offsets and to plant a second live descriptor that a wrongly accepted doorbell would reach. The key keeps its default of 0x40, so a neighbouring value such as 0x41 shows whether the decode is exact. Memory latency is switched between zero and two wait cycles, and the sink alternates between always-ready and ready one cycle in three. Together these reach word-boundary refetches under backpressure and a doorbell arriving mid-frame.

// File: rtl/tx_desc_dma.sv
module tx_desc_dma #(
  parameter int          ADDR_W   = 32,
  parameter logic [31:0] POLL_KEY = 32'h0000_0040
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [7:0]        int_status,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-3:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic [7:0]        m_tdata,
  output logic              m_tlast
);
  localparam int WA    = ADDR_W - 2;
  localparam int LEN_W = 16;

  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_BUFA, S_DATA, S_SEND, S_WBK} st_t;

  st_t               st;
  logic [ADDR_W-1:0] base_q;
  logic [WA-1:0]     desc_wa;
  logic [31:0]       ctrl_q;
  logic [ADDR_W-1:0] ptr;
  logic [LEN_W-1:0]  remain;
  logic [31:0]       word_q;
  logic              done_f, err_f;

  wire doorbell  = reg_wr && reg_sel == 2'd1 && reg_wdata == POLL_KEY;
  wire stat_clr  = reg_wr && reg_sel == 2'd2;
  wire ctrl_ok   = mem_rdata[29] && mem_rdata[28] && mem_rdata[LEN_W-1:0] != '0;
  wire err_set   = st == S_CTRL && mem_ack && mem_rdata[31] && !ctrl_ok;
  wire done_set  = st == S_WBK && mem_ack;
  wire beat      = m_tvalid && m_tready;

  assign mem_req   = st == S_CTRL || st == S_BUFA || st == S_DATA || st == S_WBK;
  assign mem_we    = st == S_WBK;
  assign mem_addr  = st == S_DATA ? ptr[ADDR_W-1:2] :
                     st == S_BUFA ? {desc_wa[WA-1:2], 2'b10} : desc_wa;
  assign mem_wdata = {1'b0, ctrl_q[30:0]};
  assign m_tvalid  = st == S_SEND;
  assign m_tdata   = word_q[{ptr[1:0], 3'b000} +: 8];
  assign m_tlast   = m_tvalid && remain == LEN_W'(1);
  assign int_status = {4'b0, err_f, done_f, 2'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      base_q  <= '0;
      desc_wa <= '0;
      ctrl_q  <= '0;
      ptr     <= '0;
      remain  <= '0;
      word_q  <= '0;
    end else begin
      if (reg_wr && reg_sel == 2'd0) base_q <= reg_wdata[ADDR_W-1:0];
      case (st)
        S_IDLE: if (doorbell) begin
          desc_wa <= {base_q[ADDR_W-1:4], 2'b00};
          st      <= S_CTRL;
        end
        S_CTRL: if (mem_ack) begin
          ctrl_q <= mem_rdata;
          remain <= mem_rdata[LEN_W-1:0];
          if (!mem_rdata[31] || !ctrl_ok) st <= S_IDLE;
          else                            st <= S_BUFA;
        end
        S_BUFA: if (mem_ack) begin
          ptr <= mem_rdata[ADDR_W-1:0];
          st  <= S_DATA;
        end
        S_DATA: if (mem_ack) begin
          word_q <= mem_rdata;
          st     <= S_SEND;
        end
        S_SEND: if (m_tready) begin
          ptr    <= ptr + 1'b1;
          remain <= remain - 1'b1;
          if (remain == LEN_W'(1))  st <= S_WBK;
          else if (ptr[1:0] == 2'b11) st <= S_DATA;
        end
        S_WBK: if (mem_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_f <= 1'b0;
      err_f  <= 1'b0;
    end else begin
      done_f <= done_set || (done_f && !(stat_clr && reg_wdata[2]));
      err_f  <= err_set  || (err_f  && !(stat_clr && reg_wdata[3]));
    end
  end

  // R7
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast));

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R8
  wb_own_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[31]);

  // R9
  done_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack |=> int_status[2] && !mem_req);

  // R6
  last_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tlast |-> m_tvalid);

  // R5
  beat_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat && !m_tlast |=> (m_tvalid || mem_req) && !mem_we);
endmodule

// File: tb/test_tx_desc_dma.sv
module test_tx_desc_dma;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 12;
  localparam int WA     = ADDR_W - 2;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [1:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic [7:0] int_status;
  logic mem_req, mem_we;
  logic [WA-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = 0;
  logic mem_ack = 0;
  logic m_tvalid, m_tlast;
  logic m_tready = 1;
  logic [7:0] m_tdata;

  tx_desc_dma #(.ADDR_W(ADDR_W)) i_tx_desc_dma (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .int_status(int_status),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast));

  always #(CLK_P/2) clk = ~clk;

  logic [31:0] mem [0:(1<<WA)-1];
  logic [7:0] exp_q[$];
  int compared = 0, mismatched = 0;
  int lat = 0, wcnt = 0, cyc = 0;
  bit slow = 0, hs_prev = 0, l_prev = 0;
  logic [7:0] d_prev = 0;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // reference: each accepted beat pops the next expected byte (R5, R6)
  always @(negedge clk) begin
    if (hs_prev) begin
      if (exp_q.size() == 0) chk("R5 unexpected byte", {24'h0, d_prev}, 32'hxxxx_xxxx);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk("R5 byte", {24'h0, d_prev}, {24'h0, e});
        chk("R6 tlast", {31'h0, l_prev}, {31'h0, exp_q.size() == 0});
      end
    end
    if (mem_ack) begin mem_ack = 0; wcnt = 0; end
    else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ack = 1;
        if (mem_we) mem[mem_addr] = mem_wdata;
        else mem_rdata = mem[mem_addr];
      end else wcnt++;
    end
    cyc++;
    m_tready = slow ? (cyc % 3 == 0) : 1'b1;
    hs_prev = m_tvalid && m_tready;
    d_prev = m_tdata;
    l_prev = m_tlast;
  end

  task automatic reg_write(logic [1:0] s, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_desc(int db, logic [31:0] w0, int bufa);
    mem[db/4] = w0; mem[db/4+1] = 0; mem[db/4+2] = bufa; mem[db/4+3] = 0;
  endtask

  task automatic fill(int bufa, int len, int seed, bit expect_it);
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = 8'(seed + i * 7);
      mem[(bufa+i)/4][8*((bufa+i)%4) +: 8] = b;
      if (expect_it) exp_q.push_back(b);
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  localparam logic [31:0] OWN = 32'h8000_0000, EOR = 32'h4000_0000,
                          FS = 32'h2000_0000, LS = 32'h1000_0000;

  initial begin
    for (int i = 0; i < (1<<WA); i++) mem[i] = 0;
    idle(3);
    // R11 reset state
    chk("R11 tvalid", {31'h0, m_tvalid}, 0);
    chk("R11 mem_req", {31'h0, mem_req}, 0);
    chk("R11 status", {24'h0, int_status}, 0);
    rst_n = 1;
    idle(2);

    // R2 R5 R6 R8 R9 aligned frame
    put_desc(32'h100, OWN | EOR | FS | LS | 5, 32'h200);
    fill(32'h200, 5, 3, 1);
    reg_write(0, 32'h100);
    reg_write(1, 32'h40);
    idle(100);
    chk("R5 all bytes sent", exp_q.size(), 0);
    chk("R8 writeback", mem[32'h100/4], EOR | FS | LS | 5);
    chk("R9 done bit", {24'h0, int_status}, 32'h04);
    reg_write(2, 32'h4);
    idle(2);
    chk("R9 clear done", {24'h0, int_status}, 0);

    // R5 R7 unaligned frame, memory latency, backpressure
    lat = 2; slow = 1;
    put_desc(32'h140, OWN | FS | LS | 9, 32'h303);
    fill(32'h303, 9, 40, 1);
    reg_write(0, 32'h14c);
    reg_write(1, 32'h40);
    idle(200);
    chk("R5 unaligned all sent", exp_q.size(), 0);
    chk("R8 writeback unaligned", mem[32'h140/4], FS | LS | 9);
    reg_write(2, 32'h4);

    // R3 not owned
    slow = 0; lat = 0;
    put_desc(32'h180, FS | LS | 4, 32'h280);
    fill(32'h280, 4, 9, 0);
    reg_write(0, 32'h180);
    reg_write(1, 32'h40);
    idle(50);
    chk("R3 status unchanged", {24'h0, int_status}, 0);
    chk("R3 word0 untouched", mem[32'h180/4], FS | LS | 4);

    // R4 missing last-segment
    put_desc(32'h180, OWN | FS | 6, 32'h280);
    reg_write(1, 32'h40);
    idle(50);
    chk("R4 error bit", {24'h0, int_status}, 32'h08);
    chk("R4 word0 untouched", mem[32'h180/4], OWN | FS | 6);
    reg_write(2, 32'h8);
    idle(2);
    chk("R9 clear error", {24'h0, int_status}, 0);

    // R4 zero length
    put_desc(32'h180, OWN | FS | LS, 32'h280);
    reg_write(1, 32'h40);
    idle(50);
    chk("R4 zero length error", {24'h0, int_status}, 32'h08);
    chk("R4 zero length untouched", mem[32'h180/4], OWN | FS | LS);
    reg_write(2, 32'hc);

    // R1 wrong key ignored, right key works
    put_desc(32'h1c0, OWN | FS | LS | 7, 32'h381);
    reg_write(0, 32'h1c0);
    reg_write(1, 32'h41);
    idle(50);
    chk("R1 wrong key no start", mem[32'h1c0/4], OWN | FS | LS | 7);
    chk("R1 wrong key status", {24'h0, int_status}, 0);
    fill(32'h381, 7, 100, 1);
    reg_write(1, 32'h40);
    idle(100);
    chk("R1 key starts frame", exp_q.size(), 0);
    chk("R1 frame written back", mem[32'h1c0/4], FS | LS | 7);
    reg_write(2, 32'h4);

    // R10 doorbell and base write while busy
    slow = 1; lat = 1;
    put_desc(32'h100, OWN | FS | LS | 3, 32'h500);
    fill(32'h500, 3, 5, 0);
    put_desc(32'h1c0, OWN | FS | LS | 12, 32'h400);
    fill(32'h400, 12, 77, 1);
    reg_write(1, 32'h40);
    idle(10);
    reg_write(0, 32'h100);
    reg_write(1, 32'h40);
    idle(250);
    chk("R10 first frame complete", exp_q.size(), 0);
    chk("R10 first writeback", mem[32'h1c0/4], FS | LS | 12);
    chk("R10 second desc untouched", mem[32'h100/4], OWN | FS | LS | 3);
    reg_write(2, 32'h4);

    // R6 single byte at offset 3
    slow = 0; lat = 0;
    put_desc(32'h180, OWN | FS | LS | 1, 32'h607);
    fill(32'h607, 1, 200, 1);
    reg_write(0, 32'h180);
    reg_write(1, 32'h40);
    idle(50);
    chk("R6 single byte sent", exp_q.size(), 0);
    chk("R9 single done", {24'h0, int_status}, 32'h04);

    summary();
  end
endmodule